// File: doc/BRIEF.md
# Post-Configuration Initialization Sequencer

This block decides when a device that has just received its configuration may enter user mode. Once the configuration-loaded input goes high, the sequencer waits a settling interval that is fixed in nanoseconds. It then counts an exact number of initialization ticks and finally raises the `user_mode` output with a single low-to-high step. The ticks come either from an internal oscillator or from a user-supplied clock. Several devices that share one user clock can therefore be held together, or released together.

The block runs on one fabric clock `clk`. Each tick source arrives as a one-cycle enable pulse in that domain, so the source choice is a multiplexer on enables and not on clocks. A static select input picks the source. The select is captured only while the sequencer is idle and is frozen from the start of the settling interval. The configuration-loaded input is asynchronous and passes through a synchronizer before the state machine uses it.

While the configuration-clear input is low, `user_mode` reads high. It stays high for a short early window after the clear is released and then drops low. It stays low until initialization completes.

Top module: `init_seq_top`

## Requirements
- R1: While `rst` is high or `cfg_clear_n` is low, the sequencer sits in its hold state and `user_mode` is 1 after the next clock edge.
- R2: After `cfg_clear_n` is first sampled high, `user_mode` stays 1 for EARLY_CYC further clock edges and is 0 after the edge that ends the window.
- R3: `cfg_loaded` passes through a SYNC_STAGES-flop synchronizer (default 2). A rise placed between edges B and B+1 starts the settling interval at edge B+SYNC_STAGES+1, or one edge after the early window ends if that is later.
- R4: The settling interval lasts ceil(SETTLE_NS*1000/CLK_PERIOD_PS) clock cycles. With the defaults this is 150 cycles. Ticks that arrive during the interval are not counted.
- R5: After the settling interval, exactly INIT_CYCLES ticks (default 4436) of the selected source are counted. `user_mode` rises after the edge that samples the last tick and is 0 before that edge.
- R6: `ext_sel`=0 selects `osc_tick` and `ext_sel`=1 selects `ext_tick`. The select is sampled on every edge while idle (hold, early window or waiting for the load), up to and including the edge that starts the settling interval.
- R7: A change of `ext_sel` after the settling interval has started has no effect on when `user_mode` rises.
- R8: Lowering `cfg_clear_n` at any time clears both counters and returns the sequencer to hold (`user_mode` 1 after the next edge). Releasing it runs the whole sequence again.
- R9: Once high after initialization, `user_mode` stays high until a reset. A fall of `cfg_loaded` after the settling interval has started is ignored.
- R10: If `cfg_loaded` never goes high, `user_mode` stays 0 after the early window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_clear_n | input | 1 | Configuration clear, active low, sampled on the clock |
| cfg_loaded | input | 1 | Configuration-loaded level, asynchronous |
| ext_sel | input | 1 | Tick source select: 0 internal oscillator, 1 user clock |
| osc_tick | input | 1 | One-cycle enable per internal oscillator period |
| ext_tick | input | 1 | One-cycle enable per user clock period |
| user_mode | output | 1 | Registered; high in hold, in the early window and in user mode |

## Verification
The embedded properties check on every cycle that the hold state forces `user_mode` high, that settling starts only from a synchronized load, and that counting is entered only from settling. They also check that the captured select stays frozen outside idle, that user mode is sticky, and that neither counter passes its limit. Only the bench's scenarios show the exact edges of R2 to R5. These edges are the early-window length, the synchronizer latency, the rounded settling length and the exact tick count over several oscillator and user-clock patterns. The scenarios also cover a select flipped mid-count, a mid-count clear, a dropped load and a load that never comes.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;

  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_EARLY  = 3'd1,
    ST_WAIT   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_COUNT  = 3'd4,
    ST_USER   = 3'd5
  } seq_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/init_seq_sync.sv
module init_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/init_seq_counter.sv
module init_seq_counter #(
  parameter int LIMIT = 16,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (clr)     cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end

  // R5: a counter never passes its terminal value
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (clr)
    en |-> (cnt < W'(LIMIT)));
endmodule

// File: rtl/init_seq_clksel.sv
module init_seq_clksel (
  input  logic clk,
  input  logic rst,
  input  logic sample,
  input  logic ext_sel,
  input  logic osc_tick,
  input  logic ext_tick,
  output logic tick
);
  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= 1'b0;
    else if (sample) sel_q <= ext_sel;
  end

  assign tick = sel_q ? ext_tick : osc_tick;

  // R7: outside idle the captured select cannot move
  p_sel_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (!sample && !$past(sample) && !$past(rst)) |-> $stable(sel_q));
endmodule

// File: rtl/init_seq_top.sv
module init_seq_top
  import init_seq_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int SETTLE_NS     = 600,
  parameter int INIT_CYCLES   = 4436,
  parameter int EARLY_CYC     = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_clear_n,
  input  logic cfg_loaded,
  input  logic ext_sel,
  input  logic osc_tick,
  input  logic ext_tick,
  output logic user_mode
);
  localparam int DELAY_CYC = max2(1, ceil_div(SETTLE_NS * 1000, CLK_PERIOD_PS));
  localparam int TMR_MAX   = max2(EARLY_CYC, DELAY_CYC);
  localparam int TW        = $clog2(TMR_MAX + 1);
  localparam int KW        = $clog2(INIT_CYCLES + 1);
  localparam logic [TW-1:0] EARLY_LAST = TW'(EARLY_CYC - 1);
  localparam logic [TW-1:0] DELAY_LAST = TW'(DELAY_CYC - 1);
  localparam logic [KW-1:0] INIT_LAST  = KW'(INIT_CYCLES - 1);

  seq_state_t st, nxt;
  logic kill, loaded_s, tick, sample;
  logic [TW-1:0] tmr_cnt;
  logic [KW-1:0] tk_cnt;
  logic tmr_clr, tmr_en, tk_clr, tk_en;

  assign kill = rst | ~cfg_clear_n;

  init_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(cfg_loaded), .q(loaded_s)
  );

  assign sample = (st == ST_HOLD) || (st == ST_EARLY) || (st == ST_WAIT);

  init_seq_clksel u_sel (
    .clk(clk), .rst(rst), .sample(sample), .ext_sel(ext_sel),
    .osc_tick(osc_tick), .ext_tick(ext_tick), .tick(tick)
  );

  always_comb begin
    nxt = st;
    unique case (st)
      ST_HOLD:   nxt = ST_EARLY;
      ST_EARLY:  if (tmr_cnt == EARLY_LAST) nxt = ST_WAIT;
      ST_WAIT:   if (loaded_s) nxt = ST_SETTLE;
      ST_SETTLE: if (tmr_cnt == DELAY_LAST) nxt = ST_COUNT;
      ST_COUNT:  if (tick && tk_cnt == INIT_LAST) nxt = ST_USER;
      ST_USER:   nxt = ST_USER;
      default:   nxt = ST_HOLD;
    endcase
  end

  assign tmr_clr = kill | (nxt != st);
  assign tmr_en  = (st == ST_EARLY) || (st == ST_SETTLE);
  assign tk_clr  = kill | (nxt != st);
  assign tk_en   = (st == ST_COUNT) && tick;

  init_seq_counter #(.LIMIT(TMR_MAX)) u_tmr (
    .clk(clk), .clr(tmr_clr), .en(tmr_en), .cnt(tmr_cnt)
  );

  init_seq_counter #(.LIMIT(INIT_CYCLES)) u_tk (
    .clk(clk), .clr(tk_clr), .en(tk_en), .cnt(tk_cnt)
  );

  always_ff @(posedge clk) begin
    if (kill) begin
      st        <= ST_HOLD;
      user_mode <= 1'b1;
    end else begin
      st        <= nxt;
      user_mode <= (nxt == ST_HOLD) || (nxt == ST_EARLY) || (nxt == ST_USER);
    end
  end

  // R8: a clear forces hold and a high output on the next edge
  p_clear_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_clear_n |=> (user_mode && st == ST_HOLD));

  // R10: settling starts only from a synchronized load
  p_settle_needs_load_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SETTLE && $past(st) == ST_WAIT && !$past(rst)) |-> $past(loaded_s));

  // R4: counting is entered only through the settling interval
  p_count_after_settle_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COUNT && !$past(rst)) |-> ($past(st) == ST_SETTLE || $past(st) == ST_COUNT));

  // R9: user mode holds its output high
  p_user_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_USER) |=> user_mode);
endmodule

// File: tb/init_seq_top_tb_top.sv
`timescale 1ns/1ps
module init_seq_top_tb_top;
  localparam int S_EARLY = 4, S_DELAY = 8, S_INIT = 20;   // 30 ns at 4 ns -> 8
  localparam int D_EARLY = 8, D_DELAY = 150, D_INIT = 4436;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1, cfg_clear_n = 1'b0, cfg_loaded = 1'b0, ext_sel = 1'b0;
  logic osc_tick = 1'b0, ext_tick = 1'b0;
  logic um, um_def;
  int ecnt = 0, po = 1, pu = 1;
  int nvec = 0, nerr = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) ecnt++;
  always @(negedge clk) begin
    osc_tick <= ((ecnt + 1) % po) == 0;
    ext_tick <= ((ecnt + 1) % pu) == 0;
  end

  init_seq_top #(.CLK_PERIOD_PS(4000), .SETTLE_NS(30), .INIT_CYCLES(S_INIT),
                 .EARLY_CYC(S_EARLY), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .cfg_clear_n(cfg_clear_n), .cfg_loaded(cfg_loaded),
    .ext_sel(ext_sel), .osc_tick(osc_tick), .ext_tick(ext_tick), .user_mode(um));

  init_seq_top dut_def_i (
    .clk(clk), .rst(rst), .cfg_clear_n(cfg_clear_n), .cfg_loaded(cfg_loaded),
    .ext_sel(ext_sel), .osc_tick(osc_tick), .ext_tick(ext_tick), .user_mode(um_def));

  task automatic chk(input logic got, input logic exp, input string req);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: user_mode=%b expected %b at edge %0d", req, got, exp, ecnt);
    end
  endtask

  task automatic at_edge(input int n);
    while (ecnt < n) begin
      @(posedge clk);
      #1;
    end
  endtask

  function automatic bit tick_at(input int e, input bit sel, input int p_o, input int p_u);
    return sel ? ((e % p_u) == 0) : ((e % p_o) == 0);
  endfunction

  function automatic int rise_edge(input int c0, input int n_init, input bit sel,
                                   input int p_o, input int p_u);
    int e = c0, n = 0;
    while (n < n_init) begin
      e++;
      if (tick_at(e, sel, p_o, p_u)) n++;
    end
    return e;
  endfunction

  function automatic logic pick(input bit d);
    return d ? um_def : um;
  endfunction

  // Full sequence: clear, release, load, settle, count.
  task automatic run(input bit sel, input int p_o, input int p_u,
                     input bit flip, input bit drop, input bit use_def);
    int ea = use_def ? D_EARLY : S_EARLY;
    int dl = use_def ? D_DELAY : S_DELAY;
    int ni = use_def ? D_INIT  : S_INIT;
    int rl, x, b, s, c0, r;
    @(negedge clk);
    cfg_clear_n = 1'b0; cfg_loaded = 1'b0; ext_sel = sel; po = p_o; pu = p_u;
    repeat (3) @(posedge clk);
    #1 chk(pick(use_def), 1'b1, "R1 hold");
    @(negedge clk);
    cfg_clear_n = 1'b1; rl = ecnt;
    x = rl + 1 + ea;
    at_edge(x - 1); chk(pick(use_def), 1'b1, "R2 early window high");
    at_edge(x);     chk(pick(use_def), 1'b0, "R2 early window end");
    repeat (2) @(posedge clk);
    @(negedge clk);
    cfg_loaded = 1'b1; b = ecnt;
    s = (b + SYNC + 1 > x + 1) ? b + SYNC + 1 : x + 1;
    c0 = s + dl;
    r = rise_edge(c0, ni, sel, p_o, p_u);
    if (flip) begin
      at_edge(s + 2); ext_sel = ~sel;
    end
    if (drop) begin
      at_edge(c0 + 2); cfg_loaded = 1'b0;
    end
    at_edge(r - 1); chk(pick(use_def), 1'b0, "R5 before last tick (R3/R4 timing)");
    at_edge(r);     chk(pick(use_def), 1'b1, "R5 rise on last tick");
    cfg_loaded = 1'b0;
    at_edge(r + 6); chk(pick(use_def), 1'b1, "R9 sticky after load drop");
  endtask

  task automatic mid_clear;
    int rl, x, s, c0, r, k;
    run(1'b0, 2, 1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    cfg_clear_n = 1'b0; cfg_loaded = 1'b0; po = 3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cfg_clear_n = 1'b1; rl = ecnt;
    x = rl + 1 + S_EARLY;
    at_edge(x + 1);
    @(negedge clk);
    cfg_loaded = 1'b1;
    at_edge(x + 30);                       // inside counting
    @(negedge clk);
    cfg_clear_n = 1'b0; k = ecnt;
    at_edge(k + 1); chk(um, 1'b1, "R8 clear mid-count");
    @(negedge clk);
    cfg_clear_n = 1'b1; rl = ecnt;
    x = rl + 1 + S_EARLY;
    s = x + 1;                             // load already high and synchronized
    c0 = s + S_DELAY;
    r = rise_edge(c0, S_INIT, 1'b0, 3, 1);
    at_edge(x); chk(um, 1'b0, "R8 restart early window");
    at_edge(r - 1); chk(um, 1'b0, "R8 restart before last tick");
    at_edge(r);     chk(um, 1'b1, "R8 restart full count");
  endtask

  task automatic no_load;
    int rl, x;
    @(negedge clk);
    cfg_clear_n = 1'b0; cfg_loaded = 1'b0; po = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cfg_clear_n = 1'b1; rl = ecnt;
    x = rl + 1 + S_EARLY;
    at_edge(x + 200); chk(um, 1'b0, "R10 no load no user mode");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 chk(um, 1'b1, "R1 reset state");
    @(negedge clk) rst = 1'b0;
    for (int sel = 0; sel < 2; sel++) begin
      for (int i = 0; i < 4; i++) begin
        int p_o = (i == 0) ? 1 : (i == 1) ? 2 : (i == 2) ? 3 : 7;
        int p_u = (i == 0) ? 4 : (i == 1) ? 1 : (i == 2) ? 5 : 2;
        run(sel[0], p_o, p_u, 1'b0, 1'b0, 1'b0);   // R6 source sweep
      end
    end
    run(1'b0, 5, 1, 1'b1, 1'b0, 1'b0);             // R7 flip to faster source
    run(1'b1, 1, 6, 1'b1, 1'b0, 1'b0);             // R7 flip to faster source
    run(1'b1, 4, 3, 1'b0, 1'b1, 1'b0);             // R9 load drop mid-count
    mid_clear();
    no_load();
    run(1'b1, 25, 1, 1'b0, 1'b0, 1'b1);            // R4/R5 default 150 + 4436
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule